// File: doc/BRIEF.md
# Banked Address Extender with Cycle-Tracked Bank Selection

This block widens a 16-bit processor address to a larger system address by adding a 4-bit bank field. Two small bank registers sit at CPU addresses $0000 and $0001. The first, the execution bank, serves opcode fetches and every ordinary access. The second, the indirection bank, serves only the data cycles of the two indirect-indexed load and store instructions. So code running in one bank can move data to and from another bank without any extra opcodes.

The block watches the opcode-fetch strobe and records each fetched opcode. It then counts bus cycles until the next fetch, and this decides cycle by cycle which register drives the bank. When the processor leaves emulation mode, both registers are bypassed and the low bits of the processor's own bank byte drive the bank. On a read of either register, the block closes the external data-bus buffer and returns the register contents itself. A register write also still reaches the memory behind the buffer.

Each clock cycle of the block stands for one processor bus cycle. The inputs describe that cycle. The bank, buffer enable and read data are valid during that same cycle. State changes take effect at the clock edge that ends the cycle.

Top module: `bank_extender`

## Requirements
- R1: After reset both bank registers hold 4'hF, so a read of $0000 and a read of $0001 both return 8'h0F.
- R2: In emulation mode (cpu_emu=1), a read (cpu_rnw=1) of $0000 or $0001 drives ext_buf_en low. reg_rdata then carries the execution register or the indirection register respectively, with bits 7:4 zero.
- R3: In emulation mode, a write (cpu_rnw=0) to $0000 or $0001 stores cpu_data[3:0] into the execution or indirection register. The new value is in effect from the next cycle. ext_buf_en stays high during the write.
- R4: In emulation mode, an opcode-fetch cycle (cpu_sync=1), and every cycle of any instruction other than opcodes 8'hB1 and 8'h91, drives sys_bank from the execution register.
- R5: The opcode is latched from cpu_data on a cycle with cpu_sync=1, and that cycle is counted as cycle 1. When the latched opcode is 8'hB1 or 8'h91, any cycle from cycle 5 up to the next opcode fetch drives sys_bank from the indirection register if cpu_addr[15:8] is non-zero.
- R6: Within an 8'hB1 or 8'h91 instruction, cycles 2 to 4 use the execution register even when their address is outside page zero. So does any later cycle whose cpu_addr[15:8] is zero.
- R7: With cpu_emu=0, sys_bank equals cpu_bank[3:0] and the registers are not decoded: ext_buf_en stays high and writes to $0000/$0001 leave both registers unchanged. Once cpu_emu returns to 1, the registers drive the bank again.
- R8: Any cycle that is not an emulation-mode register read keeps ext_buf_en high and reg_rdata at 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one period per processor bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address of the current cycle |
| cpu_sync | input | 1 | High on an opcode-fetch cycle |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_emu | input | 1 | Processor emulation flag; 0 selects native banking |
| cpu_data | input | 8 | Data on the bus this cycle (opcode on fetch, write data on writes) |
| cpu_bank | input | 8 | Processor's own bank byte, used when cpu_emu is 0 |
| sys_bank | output | 4 | Bank bits driven onto the system address bus |
| ext_buf_en | output | 1 | 1 = external data-bus buffer connected |
| reg_rdata | output | 8 | Register read data, zero-extended; 8'h00 when no register is read |

## Verification
The hardest case to reach is the data cycle of an indirect-indexed instruction. The ports alone cannot tell it apart from the pointer fetches. It only appears after an opcode fetch of 8'hB1 or 8'h91 and three further cycles. The bench drives complete bus sequences for these instructions: an operand fetch outside page zero, two page-zero pointer reads, then one or two target accesses, including a page-crossing store. It also places a target inside page zero, and runs a different opcode with the same cycle shape. This shows that the cycle count, the opcode and the page test must all agree before the indirection bank appears.

// File: rtl/bankx_pkg.sv
package bankx_pkg;

    typedef enum logic [1:0] {
        BSRC_EXEC   = 2'd0,
        BSRC_IND    = 2'd1,
        BSRC_NATIVE = 2'd2
    } bank_src_e;

    localparam logic [7:0] OPC_LDA_INDY = 8'hB1;
    localparam logic [7:0] OPC_STA_INDY = 8'h91;
    localparam logic [7:0] OPC_IDLE     = 8'hEA;

endpackage

// File: rtl/bankx_regs.sv
module bankx_regs #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BANK_W = 4,
    parameter logic [BANK_W-1:0] RST_BANK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic              emu,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] exec_bank,
    output logic [BANK_W-1:0] ind_bank,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [BANK_W-1:0] exec;
        logic [BANK_W-1:0] ind;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  hit_exec, hit_ind;

    always_comb begin
        hit_exec = emu && (addr == ADDR_W'(0));
        hit_ind  = emu && (addr == ADDR_W'(1));
        regs_d   = regs_q;
        if (!rnw && hit_exec) regs_d.exec = wdata[BANK_W-1:0];
        if (!rnw && hit_ind)  regs_d.ind  = wdata[BANK_W-1:0];
        rd_hit  = rnw && (hit_exec || hit_ind);
        rd_data = '0;
        if (rd_hit) rd_data[BANK_W-1:0] = hit_ind ? regs_q.ind : regs_q.exec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{exec: RST_BANK, ind: RST_BANK};
        else        regs_q <= regs_d;
    end

    assign exec_bank = regs_q.exec;
    assign ind_bank  = regs_q.ind;

endmodule

// File: rtl/bankx_seq.sv
module bankx_seq
    import bankx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned CNT_W    = 3,
    parameter int unsigned PAGE_LSB = 8,
    parameter int unsigned IND_IDX  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sync,
    input  logic [DATA_W-1:0] data,
    output logic              use_ind
);

    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_IND   = CNT_W'(IND_IDX);

    typedef struct packed {
        logic [DATA_W-1:0] op;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ind_op, page_zero;

    always_comb begin
        ind_op    = (seq_q.op == DATA_W'(OPC_LDA_INDY)) ||
                    (seq_q.op == DATA_W'(OPC_STA_INDY));
        page_zero = (addr[ADDR_W-1:PAGE_LSB] == '0);
        use_ind   = !sync && ind_op && (seq_q.cnt >= CNT_IND) && !page_zero;
        seq_d     = seq_q;
        if (sync) begin
            seq_d.op  = data;
            seq_d.cnt = CNT_FIRST;
        end else if (seq_q.cnt != CNT_MAX) begin
            seq_d.cnt = seq_q.cnt + CNT_FIRST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{op: DATA_W'(OPC_IDLE), cnt: '0};
        else        seq_q <= seq_d;
    end

endmodule

// File: rtl/bankx_mux.sv
module bankx_mux
    import bankx_pkg::*;
#(
    parameter int unsigned BANK_W = 4
) (
    input  logic              emu,
    input  logic              use_ind,
    input  logic [BANK_W-1:0] exec_bank,
    input  logic [BANK_W-1:0] ind_bank,
    input  logic [BANK_W-1:0] native_bank,
    output logic [BANK_W-1:0] bank,
    output bank_src_e         src
);

    always_comb begin
        if (!emu)        src = BSRC_NATIVE;
        else if (use_ind) src = BSRC_IND;
        else             src = BSRC_EXEC;
        unique case (src)
            BSRC_IND:    bank = ind_bank;
            BSRC_NATIVE: bank = native_bank;
            default:     bank = exec_bank;
        endcase
    end

endmodule

// File: rtl/bank_extender.sv
module bank_extender
    import bankx_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned BANK_W     = 4,
    parameter int unsigned CPU_BANK_W = 8,
    parameter int unsigned CNT_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  cpu_sync,
    input  logic                  cpu_rnw,
    input  logic                  cpu_emu,
    input  logic [DATA_W-1:0]     cpu_data,
    input  logic [CPU_BANK_W-1:0] cpu_bank,
    output logic [BANK_W-1:0]     sys_bank,
    output logic                  ext_buf_en,
    output logic [DATA_W-1:0]     reg_rdata
);

    localparam int unsigned PAGE_LSB = ADDR_W / 2;
    localparam int unsigned IND_IDX  = 4;

    logic [BANK_W-1:0] exec_bank, ind_bank;
    logic              rd_hit, use_ind;
    bank_src_e         bank_src;

    bankx_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .RST_BANK('1)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .rnw(cpu_rnw),
        .emu(cpu_emu), .wdata(cpu_data), .exec_bank(exec_bank),
        .ind_bank(ind_bank), .rd_hit(rd_hit), .rd_data(reg_rdata)
    );

    bankx_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .PAGE_LSB(PAGE_LSB), .IND_IDX(IND_IDX)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .sync(cpu_sync),
        .data(cpu_data), .use_ind(use_ind)
    );

    bankx_mux #(
        .BANK_W(BANK_W)
    ) u_mux (
        .emu(cpu_emu), .use_ind(use_ind), .exec_bank(exec_bank),
        .ind_bank(ind_bank), .native_bank(cpu_bank[BANK_W-1:0]),
        .bank(sys_bank), .src(bank_src)
    );

    assign ext_buf_en = !rd_hit;

endmodule

// File: rtl/bank_extender_chk.sv
module bank_extender_chk #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned BANK_W     = 4,
    parameter int unsigned CPU_BANK_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     cpu_addr,
    input logic                  cpu_sync,
    input logic                  cpu_rnw,
    input logic                  cpu_emu,
    input logic [DATA_W-1:0]     cpu_data,
    input logic [CPU_BANK_W-1:0] cpu_bank,
    input logic [BANK_W-1:0]     sys_bank,
    input logic                  ext_buf_en,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic [BANK_W-1:0]     exec_q,
    input logic [BANK_W-1:0]     ind_q
);

    localparam int unsigned PAGE_LSB = ADDR_W / 2;

    logic reg_addr;
    assign reg_addr = (cpu_addr == ADDR_W'(0)) || (cpu_addr == ADDR_W'(1));

    // R2
    reg_read_isolates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_emu && cpu_rnw && reg_addr) |-> !ext_buf_en);

    // R8
    buf_closed_only_on_reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_buf_en |-> (cpu_emu && cpu_rnw && reg_addr));

    // R2
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:BANK_W] == '0);

    // R3
    exec_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_emu && !cpu_rnw && cpu_addr == ADDR_W'(0)) |=> (exec_q == $past(cpu_data[BANK_W-1:0])));

    // R3
    ind_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_emu && !cpu_rnw && cpu_addr == ADDR_W'(1)) |=> (ind_q == $past(cpu_data[BANK_W-1:0])));

    // R3
    write_keeps_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rnw |-> ext_buf_en);

    // R7
    native_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_emu |-> (sys_bank == cpu_bank[BANK_W-1:0]));

    // R7
    native_no_reg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_emu |=> ($stable(exec_q) && $stable(ind_q)));

    // R4
    fetch_uses_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_emu && cpu_sync) |-> (sys_bank == exec_q));

    // R6
    page_zero_uses_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_emu && cpu_addr[ADDR_W-1:PAGE_LSB] == '0) |-> (sys_bank == exec_q));

endmodule

bind bank_extender bank_extender_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .CPU_BANK_W(CPU_BANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_sync(cpu_sync),
    .cpu_rnw(cpu_rnw), .cpu_emu(cpu_emu), .cpu_data(cpu_data),
    .cpu_bank(cpu_bank), .sys_bank(sys_bank), .ext_buf_en(ext_buf_en),
    .reg_rdata(reg_rdata), .exec_q(exec_bank), .ind_q(ind_bank)
);

// File: tb/bank_extender_bench.sv
module bank_extender_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h2000;
    logic        cpu_sync = 1'b0;
    logic        cpu_rnw = 1'b1;
    logic        cpu_emu = 1'b1;
    logic [7:0]  cpu_data = 8'h00;
    logic [7:0]  cpu_bank = 8'h00;
    logic [3:0]  sys_bank;
    logic        ext_buf_en;
    logic [7:0]  reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference state, built from the requirements
    logic [3:0] m_exec = 4'hF;
    logic [3:0] m_ind  = 4'hF;
    logic [7:0] m_op   = 8'hEA;
    int         m_cnt  = 0;

    always #10 clk = ~clk;

    bank_extender u_bank_extender (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_sync(cpu_sync),
        .cpu_rnw(cpu_rnw), .cpu_emu(cpu_emu), .cpu_data(cpu_data),
        .cpu_bank(cpu_bank), .sys_bank(sys_bank), .ext_buf_en(ext_buf_en),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one bus cycle: drive at falling edge, compare mid-phase, update model
    task automatic bus(input string req, input logic [15:0] a, input logic s,
                       input logic rnw, input logic emu, input logic [7:0] d,
                       input logic [7:0] nb);
        logic [3:0] e_bank;
        logic       e_buf;
        logic [7:0] e_rd;
        logic       ind_cycle;
        @(negedge clk);
        cpu_addr = a; cpu_sync = s; cpu_rnw = rnw; cpu_emu = emu;
        cpu_data = d; cpu_bank = nb;
        #2;
        ind_cycle = !s && (m_op == 8'hB1 || m_op == 8'h91) && m_cnt >= 4 && a[15:8] != 8'h00;
        if (!emu)           e_bank = nb[3:0];
        else if (ind_cycle) e_bank = m_ind;
        else                e_bank = m_exec;
        e_buf = 1'b1; e_rd = 8'h00;
        if (emu && rnw && a == 16'h0000) begin e_buf = 1'b0; e_rd = {4'h0, m_exec}; end
        if (emu && rnw && a == 16'h0001) begin e_buf = 1'b0; e_rd = {4'h0, m_ind}; end
        check(req, "sys_bank", 32'(sys_bank), 32'(e_bank));
        check(req, "ext_buf_en", 32'(ext_buf_en), 32'(e_buf));
        check(req, "reg_rdata", 32'(reg_rdata), 32'(e_rd));
        if (emu && !rnw && a == 16'h0000) m_exec = d[3:0];
        if (emu && !rnw && a == 16'h0001) m_ind  = d[3:0];
        if (s) begin m_op = d; m_cnt = 1; end
        else if (m_cnt < 7) m_cnt++;
    endtask

    task automatic t_reset;
        bus("R1", 16'h0000, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        check("R1", "exec reset read", 32'(reg_rdata), 32'h0F);
        bus("R1", 16'h0001, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        check("R1", "ind reset read", 32'(reg_rdata), 32'h0F);
    endtask

    task automatic t_reg_access;
        bus("R3", 16'h0000, 1'b0, 1'b0, 1'b1, 8'hA3, 8'h00);
        check("R3", "buffer open on write", 32'(ext_buf_en), 32'h1);
        bus("R3", 16'h0001, 1'b0, 1'b0, 1'b1, 8'h59, 8'h00);
        bus("R2", 16'h0000, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        check("R2", "exec readback", 32'(reg_rdata), 32'h03);
        check("R2", "buffer closed", 32'(ext_buf_en), 32'h0);
        bus("R2", 16'h0001, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        check("R2", "ind readback", 32'(reg_rdata), 32'h09);
        bus("R8", 16'h0002, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        check("R8", "non-register read", 32'(ext_buf_en), 32'h1);
        bus("R8", 16'h1000, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
    endtask

    task automatic t_plain_instr;
        bus("R4", 16'h2000, 1'b1, 1'b1, 1'b1, 8'hAD, 8'h00);
        bus("R4", 16'h2001, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        bus("R4", 16'h2002, 1'b0, 1'b1, 1'b1, 8'h40, 8'h00);
        bus("R4", 16'h4000, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        check("R4", "plain load bank", 32'(sys_bank), 32'h3);
    endtask

    task automatic t_lda_indy;
        bus("R4", 16'h2003, 1'b1, 1'b1, 1'b1, 8'hB1, 8'h00);
        bus("R6", 16'h2004, 1'b0, 1'b1, 1'b1, 8'h10, 8'h00);
        check("R6", "operand fetch uses exec", 32'(sys_bank), 32'h3);
        bus("R6", 16'h0010, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        bus("R6", 16'h0011, 1'b0, 1'b1, 1'b1, 8'h50, 8'h00);
        bus("R5", 16'h5000, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        check("R5", "load target uses ind", 32'(sys_bank), 32'h9);
        bus("R4", 16'h2005, 1'b1, 1'b1, 1'b1, 8'hEA, 8'h00);
        check("R4", "next fetch uses exec", 32'(sys_bank), 32'h3);
        bus("R4", 16'h2006, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
    endtask

    task automatic t_sta_indy_cross;
        bus("R4", 16'h2006, 1'b1, 1'b1, 1'b1, 8'h91, 8'h00);
        bus("R6", 16'h2007, 1'b0, 1'b1, 1'b1, 8'h20, 8'h00);
        bus("R6", 16'h0020, 1'b0, 1'b1, 1'b1, 8'hF0, 8'h00);
        bus("R6", 16'h0021, 1'b0, 1'b1, 1'b1, 8'h50, 8'h00);
        bus("R5", 16'h50FF, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        bus("R5", 16'h5100, 1'b0, 1'b0, 1'b1, 8'h77, 8'h00);
        check("R5", "store target uses ind", 32'(sys_bank), 32'h9);
    endtask

    task automatic t_zp_target;
        bus("R4", 16'h2008, 1'b1, 1'b1, 1'b1, 8'hB1, 8'h00);
        bus("R6", 16'h2009, 1'b0, 1'b1, 1'b1, 8'h30, 8'h00);
        bus("R6", 16'h0030, 1'b0, 1'b1, 1'b1, 8'h40, 8'h00);
        bus("R6", 16'h0031, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        bus("R6", 16'h0045, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        check("R6", "page-zero target uses exec", 32'(sys_bank), 32'h3);
    endtask

    task automatic t_other_opcode;
        bus("R4", 16'h200A, 1'b1, 1'b1, 1'b1, 8'hB2, 8'h00);
        bus("R4", 16'h200B, 1'b0, 1'b1, 1'b1, 8'h30, 8'h00);
        bus("R4", 16'h0030, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        bus("R4", 16'h0031, 1'b0, 1'b1, 1'b1, 8'h60, 8'h00);
        bus("R4", 16'h6000, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        check("R4", "other opcode target uses exec", 32'(sys_bank), 32'h3);
    endtask

    task automatic t_native;
        bus("R7", 16'h3000, 1'b1, 1'b1, 1'b0, 8'hEA, 8'h37);
        check("R7", "native bank", 32'(sys_bank), 32'h7);
        bus("R7", 16'h0000, 1'b0, 1'b1, 1'b0, 8'h00, 8'h3C);
        check("R7", "native reg read passes", 32'(ext_buf_en), 32'h1);
        bus("R7", 16'h0000, 1'b0, 1'b0, 1'b0, 8'h05, 8'h3C);
        bus("R7", 16'h0001, 1'b0, 1'b0, 1'b0, 8'h06, 8'h3C);
        bus("R7", 16'h0000, 1'b0, 1'b1, 1'b1, 8'h00, 8'h3C);
        check("R7", "exec unchanged by native write", 32'(reg_rdata), 32'h03);
        bus("R7", 16'h0001, 1'b0, 1'b1, 1'b1, 8'h00, 8'h3C);
        check("R7", "ind unchanged by native write", 32'(reg_rdata), 32'h09);
        bus("R7", 16'h3001, 1'b1, 1'b1, 1'b1, 8'hEA, 8'h3C);
        check("R7", "back to exec bank", 32'(sys_bank), 32'h3);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reg_access();
        t_plain_instr();
        t_lda_indy();
        t_sta_indy_cross();
        t_zp_target();
        t_other_opcode();
        t_native();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule